// File: doc/BRIEF.md
# Power-Mode Voltage Request Controller

This block drives one request pin to an external switching regulator on behalf of a single voltage domain. It watches the 2-bit power state of each power domain in that voltage domain. When at least one enabled domain is on, it asks for the higher supply. When every enabled domain is in retention or off, it asks for the lower supply. The pin is driven from a register, and its polarity can be set.

Each change of the request level starts a settling wait. The length of the wait is a count of system clock cycles set by software. While the wait runs, a busy flag is high and the ready flag is low. Any change in domain state during the wait is acted on only when the wait ends. A wake-up seen at any point during a lowering wait is remembered, so the raise follows at once even if the wake-up was only a short pulse. When the enable input is clear, the pin is held at the high-voltage level and nothing else happens.

Top module: `vmode_req_ctrl`

## Requirements
- R1: The aggregate is "on" when any domain whose `domMask` bit is 1 has bit 1 of its state code set. The codes are 00 off, 01 retention, 11 on and 10 reserved, which counts as on. A domain whose mask bit is 0 is ignored. With no domain enabled the aggregate is low-power.
- R2: With `polInv`=0, `reqPin` equals the logical level, where 1 requests the higher voltage. With `polInv`=1, `reqPin` is the inverse of the level.
- R3: While `enable` is 0, from the next clock on the level is high, `ready`=1 and `busy`=0, even if a wait was running, and changes in domain state cause no transition.
- R4: With `enable`=1 and `ready`=1, a change of the aggregate that disagrees with the current level flips the level at the next clock edge, and `busy` rises and `ready` falls at that same edge.
- R5: After a level flip, `busy` stays high for `stabCount`+1 cycles and then `ready` returns. With `stabCount`=0, `ready` is high one cycle after the pin changes.
- R6: The level does not change during a wait. If the aggregate disagrees with the level when the wait ends, the opposite transition starts at once and `busy` stays high.
- R7: If any enabled domain reports on at any cycle of a lowering wait, a raise starts when that wait ends, even if the domains have gone back to low-power by then.
- R8: A change of `polInv` changes `reqPin` at the next clock edge, and `busy` and `ready` are unaffected.
- R9: Reset gives level high, `ready`=1, `busy`=0 and `reqPin`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Voltage-mode request mechanism enable |
| polInv | input | 1 | Pin polarity: 0 pin follows level, 1 pin is inverted |
| stabCount | input | 16 | Settling wait length in clock cycles |
| domMask | input | 4 | Per-domain participation mask |
| domState | input | 8 | Per-domain 2-bit state codes, domain i at bits 2i+1:2i |
| reqPin | output | 1 | Registered voltage request pin |
| ready | output | 1 | Supply settled at the requested level |
| busy | output | 1 | Settling wait in progress |

## Verification
The bench checks that the reserved code 10 counts as on, that a masked-off domain has no effect, and that an empty mask means low-power. A design that got any of these wrong would lower or raise the supply on the wrong states. It measures the busy length for a zero count and for non-zero counts, which catches off-by-one errors in the wait. It also tests a change in domain state during a raise wait, and a one-cycle wake pulse during a lowering wait. A design that acted early, or dropped the pulse, would move the pin in the middle of a wait or leave the supply low while a domain wants power. Clearing `enable` in the middle of a wait, and flipping polarity while the block is ready, show whether an abort or a polarity change leaves `busy` stuck or starts a wait that should not happen.

// File: rtl/vmode_pkg.sv
package vmode_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic toggleLvl;
    logic forceOn;
  } dpStrobe_t;

  typedef enum logic {
    ST_STEADY = 1'b0,
    ST_SETTLE = 1'b1
  } ctrlState_t;

endpackage

// File: rtl/vmode_dp.sv
module vmode_dp
  import vmode_pkg::*;
#(
  parameter int NUM_DOM = 4,
  parameter int CNT_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dpStrobe_t            strobe,
  input  logic                 polInv,
  input  logic [CNT_W-1:0]     stabCount,
  input  logic [NUM_DOM-1:0]   domMask,
  input  logic [2*NUM_DOM-1:0] domState,
  output logic                 wantHigh,
  output logic                 lvl,
  output logic                 cntZero,
  output logic                 reqPin
);

  logic [NUM_DOM-1:0] domOn;
  logic               anyOn;
  logic [CNT_W-1:0]   cnt;
  logic               pendRaise;
  logic               lvlNext;

  // bit 1 of each state code marks on (11) or reserved-as-on (10)
  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    assign domOn[g] = domMask[g] & domState[2*g+1];
  end

  assign anyOn    = |domOn;
  assign wantHigh = anyOn | pendRaise;
  assign cntZero  = (cnt == '0);

  always_comb begin
    lvlNext = lvl;
    if (strobe.forceOn)        lvlNext = 1'b1;
    else if (strobe.toggleLvl) lvlNext = ~lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl    <= 1'b1;
      reqPin <= 1'b1;
    end else begin
      lvl    <= lvlNext;
      reqPin <= lvlNext ^ polInv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (strobe.forceOn) cnt <= '0;
    else if (strobe.loadCnt) cnt <= stabCount;
    else if (strobe.decCnt)  cnt <= cnt - 1'b1;
  end

  // sticky wake request seen while the level is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               pendRaise <= 1'b0;
    else if (strobe.forceOn || strobe.loadCnt) pendRaise <= 1'b0;
    else if (!lvl && anyOn)                   pendRaise <= 1'b1;
  end

endmodule

// File: rtl/vmode_fsm.sv
module vmode_fsm
  import vmode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      wantHigh,
  input  logic      lvl,
  input  logic      cntZero,
  output dpStrobe_t strobe,
  output logic      ready,
  output logic      busy
);

  ctrlState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (!enable) begin
      strobe.forceOn = 1'b1;
      stateNext      = ST_STEADY;
    end else begin
      unique case (state)
        ST_STEADY: begin
          if (wantHigh != lvl) begin
            strobe.toggleLvl = 1'b1;
            strobe.loadCnt   = 1'b1;
            stateNext        = ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (!cntZero) begin
            strobe.decCnt = 1'b1;
          end else if (wantHigh != lvl) begin
            strobe.toggleLvl = 1'b1;
            strobe.loadCnt   = 1'b1;
          end else begin
            stateNext = ST_STEADY;
          end
        end
        default: stateNext = ST_STEADY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_STEADY;
    else        state <= stateNext;
  end

  assign ready = (state == ST_STEADY);
  assign busy  = (state == ST_SETTLE);

endmodule

// File: rtl/vmode_req_ctrl.sv
module vmode_req_ctrl
  import vmode_pkg::*;
#(
  parameter int NUM_DOM = 4,
  parameter int CNT_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 polInv,
  input  logic [CNT_W-1:0]     stabCount,
  input  logic [NUM_DOM-1:0]   domMask,
  input  logic [2*NUM_DOM-1:0] domState,
  output logic                 reqPin,
  output logic                 ready,
  output logic                 busy
);

  dpStrobe_t strobe;
  logic      wantHigh;
  logic      lvl;
  logic      cntZero;

  vmode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .wantHigh (wantHigh),
    .lvl      (lvl),
    .cntZero  (cntZero),
    .strobe   (strobe),
    .ready    (ready),
    .busy     (busy)
  );

  vmode_dp #(
    .NUM_DOM (NUM_DOM),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .polInv    (polInv),
    .stabCount (stabCount),
    .domMask   (domMask),
    .domState  (domState),
    .wantHigh  (wantHigh),
    .lvl       (lvl),
    .cntZero   (cntZero),
    .reqPin    (reqPin)
  );

endmodule

// File: rtl/vmode_req_chk.sv
module vmode_req_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic polInv,
  input logic reqPin,
  input logic ready,
  input logic busy
);

  // R3
  disable_forces_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (ready && !busy));

  // R4
  wait_starts_with_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && ($past(polInv) == $past(polInv, 2))) |-> (reqPin != $past(reqPin)));

  // R5
  ready_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready != busy);

  // R9
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (ready && !busy && reqPin);
    end
  end

endmodule

bind vmode_req_ctrl vmode_req_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .enable (enable),
  .polInv (polInv),
  .reqPin (reqPin),
  .ready  (ready),
  .busy   (busy)
);

// File: tb/tb_vmode_req_ctrl.sv
`timescale 1ns/1ps
module tb_vmode_req_ctrl;

  localparam int ND = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable;
  logic          polInv;
  logic [CW-1:0] stabCount;
  logic [ND-1:0] domMask;
  logic [2*ND-1:0] domState;
  logic          reqPin, ready, busy;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit modelCmp = 0;

  always #10 clk = ~clk;

  vmode_req_ctrl #(.NUM_DOM(ND), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .polInv(polInv),
    .stabCount(stabCount), .domMask(domMask), .domState(domState),
    .reqPin(reqPin), .ready(ready), .busy(busy)
  );

  // aggregate per R1
  function automatic logic aggOn(logic [2*ND-1:0] st, logic [ND-1:0] m);
    logic r = 1'b0;
    for (int i = 0; i < ND; i++) r |= m[i] & st[2*i+1];
    return r;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural expectation of level and wait, from R1..R9
  logic    mLvl, mBusy, mPend, mPin;
  int      mCnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mLvl = 1; mBusy = 0; mPend = 0; mCnt = 0; mPin = 1;
    end else begin
      logic on, want, oldLvl;
      on = aggOn(domState, domMask);
      oldLvl = mLvl;
      want = on | mPend;
      if (!enable) begin
        mLvl = 1; mBusy = 0; mPend = 0; mCnt = 0;
      end else if (!mBusy || mCnt == 0) begin
        if (want != mLvl) begin
          mLvl = ~mLvl; mCnt = int'(stabCount); mBusy = 1; mPend = 0;
        end else begin
          mBusy = 0;
          if (!oldLvl && on) mPend = 1;
        end
      end else begin
        mCnt--;
        if (!oldLvl && on) mPend = 1;
      end
      mPin = mLvl ^ polInv;
    end
  end

  always @(negedge clk) begin
    if (modelCmp && rst_n) begin
      check("R2 pin vs expected", reqPin, mPin);
      check("R5 busy vs expected", busy, mBusy);
      check("R4 ready vs expected", ready, ~mBusy);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // counts busy samples until ready
  task automatic waitReady(output int n);
    n = 0;
    while (busy && n < 100000) begin
      n++;
      tick();
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int n;
    rst_n = 0; enable = 0; polInv = 0; stabCount = 3;
    domMask = 4'hF; domState = 8'hFF;
    tick(3);
    check("R9 ready after reset", ready, 1);
    check("R9 busy after reset", busy, 0);
    check("R9 pin after reset", reqPin, 1);
    rst_n = 1;
    tick();
    enable = 1;
    tick(2);
    check("R4 no spurious transition", busy, 0);
    check("R4 pin stays high", reqPin, 1);

    // R1 retention/off lowers; R4 timing; R5 length
    domState = 8'b01_00_01_00;
    tick();
    check("R4 pin lowered next cycle", reqPin, 0);
    check("R4 busy rises", busy, 1);
    check("R4 ready falls", ready, 0);
    waitReady(n);
    check("R5 busy length stab=3", n == 4, 1);
    check("R5 ready after wait", ready, 1);

    // R1 reserved code 10 counts as on
    domState = 8'b01_10_01_00;
    tick();
    check("R1 reserved code raises", reqPin, 1);
    waitReady(n);

    // R1 masked domain ignored
    domMask = 4'b0001; domState = 8'b11_11_11_00;
    tick();
    check("R1 masked on domains ignored", reqPin, 0);
    waitReady(n);
    domState = 8'b11_11_11_01;
    tick(2);
    check("R1 retention stays low", reqPin, 0);
    check("R1 no wait started", busy, 0);
    domMask = 4'b0000; domState = 8'hFF;
    tick(2);
    check("R1 empty mask is low-power", reqPin, 0);
    check("R1 empty mask ready", ready, 1);

    // R5 zero count
    domMask = 4'hF; stabCount = 0;
    tick();
    check("R5 zero count pin up", reqPin, 1);
    check("R5 zero count busy", busy, 1);
    tick();
    check("R5 zero count ready next cycle", ready, 1);

    // R6 change during raise wait deferred
    stabCount = 5; domState = 8'h00;
    tick();
    waitReady(n);
    domState = 8'hFF;
    tick();
    check("R6 raise started", reqPin, 1);
    domState = 8'h00;
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R6 pin held during wait", reqPin, 1);
    end
    tick();
    check("R6 lowering after wait", reqPin, 0);
    check("R6 busy continues", busy, 1);
    waitReady(n);
    check("R6 second wait length", n == 6, 1);

    // R7 short wake pulse during lowering wait
    domState = 8'hFF;
    tick(); waitReady(n);
    domState = 8'h00;
    tick();
    check("R7 lowering started", reqPin, 0);
    domState = 8'h0C;
    tick();
    domState = 8'h00;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R7 pin low during wait", reqPin, 0);
    end
    tick();
    check("R7 raise after wait", reqPin, 1);
    check("R7 busy continues", busy, 1);
    waitReady(n);
    waitReady(n);
    check("R7 settles low again", reqPin, 0);

    // R8 polarity change
    polInv = 1;
    tick();
    check("R8 pin flips with polarity", reqPin, 1);
    check("R8 no wait started", busy, 0);
    check("R2 inverted low level", reqPin, ~1'b0);
    polInv = 0;
    tick();
    check("R8 pin restored", reqPin, 0);

    // R3 disable mid-wait
    stabCount = 20; domState = 8'hFF;
    tick(3);
    domState = 8'h00;
    tick(4);
    check("R3 in wait before disable", busy, 1);
    enable = 0;
    tick();
    check("R3 pin high on disable", reqPin, 1);
    check("R3 ready on disable", ready, 1);
    check("R3 busy cleared", busy, 0);
    domState = 8'h55;
    tick(3);
    check("R3 no transition while disabled", busy, 0);
    polInv = 1;
    tick();
    check("R2 inverted high level", reqPin, 0);
    polInv = 0;
    tick();

    // random phase against expectation
    modelCmp = 1;
    enable = 1;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0) domState = 8'($urandom());
      if ($urandom_range(0, 31) == 0) domMask = 4'($urandom());
      if ($urandom_range(0, 47) == 0) polInv = ~polInv;
      if ($urandom_range(0, 99) == 0) enable = ~enable;
      if ($urandom_range(0, 15) == 0) stabCount = 16'($urandom_range(0, 7));
      tick();
    end
    modelCmp = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule